// File: doc/BRIEF.md
# Two-Unit Interrupt Pending Controller

This block collects interrupt lines from peripherals into a pending register and raises one request line toward the chipset interrupt summary. It has a primary unit and a secondary unit. Peripherals set pending bits through a post vector and remove them through a clear vector. Software reaches the block through byte-wide I/O register accesses. The primary unit holds the pending bits and an enable mask, and it drives the request. The secondary unit only keeps a mask byte and never raises a request. The block has no priority resolution, no vectoring and no initialization command sequence.

In a typical system the console UART drives pending bit 4 (value 0x10). The request output feeds bit 55 of the chipset's interrupt summary. Software masks lines by writing a 1 to the matching mask bit. The block stores the complement of that byte as its enable mask. Software then reads the pending byte and acknowledges one line by number.

Top module: `irq_cascade_ctl`

## Requirements
- R1: After reset the pending register is 0x00 and every line is masked. The request is low, a read of the primary mask returns 0xFF, and a read of the secondary mask returns 0x00.
- R2: A nonzero post vector ORs its bits into the pending register on the next clock edge, and a clear vector removes its bits on that edge. When post and clear name the same bit in the same cycle, the bit ends cleared.
- R3: A byte write to offset 0x21 stores the complement of the data as the enable mask, so a written 1 masks that line. A byte read of 0x21 returns the byte last written.
- R4: The request output is high exactly when the pending bits ANDed with the enable mask are nonzero. It follows each post, clear, mask write and acknowledge in the cycle after the edge that applies it.
- R5: A byte write to offset 0x20 clears the pending bit whose number is the low nibble of the data. The upper nibble is ignored, and a nibble of 8 to 15 clears nothing.
- R6: A read of offset 0x20 with a byte access (size code 0) or an 8-byte access (size code 3) returns the pending byte zero-extended to 64 bits.
- R7: A byte read of offset 0xA0 returns zero. A byte write to 0xA0 is accepted without error and leaves the pending register and the request unchanged.
- R8: A byte write to offset 0xA1 is stored and is read back at 0xA1. It never changes the pending register or the request.
- R9: Every other access returns an error response with zero read data and changes no state. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The accepted accesses are the byte writes to 0x20, 0x21, 0xA0 and 0xA1, and the reads listed in R3, R6, R7 and R8.
- R10: Each cycle with busValid high produces exactly one busAck pulse, carrying busRdata and busErr, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busValid | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | I/O offset |
| busSize | input | 2 | Access size code (0,1,2,3 = 1,2,4,8 bytes) |
| busWdata | input | 8 | Write data byte |
| busAck | output | 1 | Response strobe, one cycle after busValid |
| busRdata | output | 64 | Read data, valid with busAck |
| busErr | output | 1 | Error response, valid with busAck |
| postVec | input | 8 | Pending bits to set |
| clearVec | input | 8 | Pending bits to remove |
| irqReq | output | 1 | Interrupt request toward the chipset summary |

## Verification
The bench builds the block with its default parameters: eight lines, 8-bit offsets, the primary unit at 0x20/0x21, the secondary unit at 0xA0/0xA1 and a 64-bit read bus. With these values every pending bit can be posted, masked and acknowledged by number. Acknowledge nibbles from 8 to 15 fall outside the register, so the bench can show that such a write clears nothing. The wide read bus lets the bench check the zero-extension of the 8-byte pending read. It also covers the error path for 2- and 4-byte sizes.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_QUAD = 2'd3;

  typedef struct packed {
    logic       wrPriMask;
    logic       wrSecMask;
    logic       ack;
    logic [3:0] ackIdx;
    logic       rdPend;
    logic       rdPriMask;
    logic       rdSecMask;
    logic       err;
  } strobe_t;
endpackage

// File: rtl/irq_cascade_decode.sv
module irq_cascade_decode
  import irq_cascade_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] SEC_BASE = 8'hA0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [3:0]        ackNibble,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] PRI_MASK = PRI_BASE + 1'b1;
  localparam logic [ADDR_W-1:0] SEC_MASK = SEC_BASE + 1'b1;

  logic isByte, isQuad, atPriCmd, atPriMask, atSecCmd, atSecMask;
  logic wrOk, rdOk, wrByte, rdAny;

  always_comb begin
    isByte    = (busSize == SZ_BYTE);
    isQuad    = (busSize == SZ_QUAD);
    atPriCmd  = (busAddr == PRI_BASE);
    atPriMask = (busAddr == PRI_MASK);
    atSecCmd  = (busAddr == SEC_BASE);
    atSecMask = (busAddr == SEC_MASK);

    wrByte = busValid && busWrite && isByte;
    rdAny  = busValid && !busWrite;

    wrOk = isByte && (atPriCmd || atPriMask || atSecCmd || atSecMask);
    rdOk = (atPriCmd && (isByte || isQuad)) ||
           (isByte && (atPriMask || atSecCmd || atSecMask));

    stb.wrPriMask = wrByte && atPriMask;
    stb.wrSecMask = wrByte && atSecMask;
    stb.ack       = wrByte && atPriCmd;
    stb.ackIdx    = ackNibble;
    stb.rdPend    = rdAny && atPriCmd && (isByte || isQuad);
    stb.rdPriMask = rdAny && isByte && atPriMask;
    stb.rdSecMask = rdAny && isByte && atSecMask;
    stb.err       = busValid && !(busWrite ? wrOk : rdOk);
  end
endmodule

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
  import irq_cascade_pkg::*;
#(
  parameter int LINES = 8,
  parameter int RD_W  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  strobe_t          stb,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] postVec,
  input  logic [LINES-1:0] clearVec,
  output logic             busAck,
  output logic [RD_W-1:0]  busRdata,
  output logic             busErr,
  output logic             irqReq
);
  logic [LINES-1:0] pending, enable, secMask, ackHit, pendNext;
  logic [RD_W-1:0]  rdNext;

  for (genvar i = 0; i < LINES; i++) begin : g_ack
    assign ackHit[i] = stb.ack && (stb.ackIdx == 4'(i));
  end

  always_comb begin
    pendNext = (pending | postVec) & ~clearVec & ~ackHit;
    rdNext   = '0;
    if (stb.rdPend)    rdNext[LINES-1:0] = pending;
    if (stb.rdPriMask) rdNext[LINES-1:0] = ~enable;
    if (stb.rdSecMask) rdNext[LINES-1:0] = secMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      enable   <= '0;
      secMask  <= '0;
      busAck   <= 1'b0;
      busErr   <= 1'b0;
      busRdata <= '0;
    end else begin
      pending  <= pendNext;
      if (stb.wrPriMask) enable  <= ~wdata;
      if (stb.wrSecMask) secMask <= wdata;
      busAck   <= busValid;
      busErr   <= stb.err;
      busRdata <= rdNext;
    end
  end

  assign irqReq = |(pending & enable);
endmodule

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl
  import irq_cascade_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int RD_W   = 64,
  parameter logic [ADDR_W-1:0] PRI_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] SEC_BASE = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [LINES-1:0]  busWdata,
  output logic              busAck,
  output logic [RD_W-1:0]   busRdata,
  output logic              busErr,
  input  logic [LINES-1:0]  postVec,
  input  logic [LINES-1:0]  clearVec,
  output logic              irqReq
);
  strobe_t stb;

  irq_cascade_decode #(.ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)) decode_i (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .ackNibble(busWdata[3:0]),
    .stb      (stb)
  );

  irq_cascade_regs #(.LINES(LINES), .RD_W(RD_W)) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .stb     (stb),
    .wdata   (busWdata),
    .postVec (postVec),
    .clearVec(clearVec),
    .busAck  (busAck),
    .busRdata(busRdata),
    .busErr  (busErr),
    .irqReq  (irqReq)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int RD_W   = 64,
  parameter logic [ADDR_W-1:0] SEC_BASE = 8'hA0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busAck,
  input logic [RD_W-1:0]   busRdata,
  input logic              busErr,
  input logic [LINES-1:0]  postVec,
  input logic [LINES-1:0]  clearVec,
  input logic              irqReq
);
  logic quietBus;
  assign quietBus = (postVec == '0) && (clearVec == '0);

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> (!irqReq && !busAck));

  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clearVec == '1) |=> !irqReq);

  p_ack_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busAck);

  p_ack_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busValid));

  p_err_no_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busAck && busRdata == '0));

  p_sec_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == SEC_BASE && busSize == 2'd0 && quietBus)
      |=> $stable(irqReq));

  p_sec_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == SEC_BASE + 1'b1 && busSize == 2'd0 && quietBus)
      |=> $stable(irqReq));
endmodule

bind irq_cascade_ctl irq_cascade_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .RD_W(RD_W), .SEC_BASE(SEC_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busAck(busAck), .busRdata(busRdata),
  .busErr(busErr), .postVec(postVec), .clearVec(clearVec), .irqReq(irqReq)
);

// File: tb/irq_cascade_ctl_tb.sv
module irq_cascade_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [7:0]  busWdata = '0;
  logic        busAck, busErr, irqReq;
  logic [63:0] busRdata;
  logic [7:0]  postVec = '0, clearVec = '0;

  int nChecks = 0, nFails = 0;
  logic [63:0] gotData;
  logic        gotErr, gotAck;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctl dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busErr(busErr),
    .postVec(postVec), .clearVec(clearVec), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] addr, input logic [1:0] size,
                     input logic [7:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busSize = size; busWdata = data;
    @(negedge clk);
    busValid = 1'b0;
    gotAck = busAck; gotErr = busErr; gotData = busRdata;
  endtask

  task automatic pulse(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk);
    postVec = p; clearVec = c;
    @(negedge clk);
    postVec = '0; clearVec = '0;
  endtask

  task automatic readPend(input string req, input logic [63:0] exp);
    acc(1'b0, 8'h20, 2'd0, 8'h00);
    chk(req, gotData, exp);
  endtask

  task automatic test_reset;
    chk("R1 irq", irqReq, 0);
    readPend("R1 pending", 64'h0);
    acc(1'b0, 8'h21, 2'd0, 8'h00);
    chk("R1 primary mask", gotData, 64'hFF);
    acc(1'b0, 8'hA1, 2'd0, 8'h00);
    chk("R1 secondary mask", gotData, 64'h00);
  endtask

  task automatic test_post_clear;
    pulse(8'h10, 8'h00);
    chk("R4 masked irq", irqReq, 0);
    readPend("R2 post", 64'h10);
    pulse(8'h05, 8'h04);
    readPend("R2 clear wins", 64'h11);
    pulse(8'h00, 8'h01);
    readPend("R2 clear", 64'h10);
  endtask

  task automatic test_mask;
    acc(1'b1, 8'h21, 2'd0, 8'hEF);
    chk("R3 unmask irq", irqReq, 1);
    acc(1'b0, 8'h21, 2'd0, 8'h00);
    chk("R3 mask readback", gotData, 64'hEF);
    acc(1'b1, 8'h21, 2'd0, 8'hFF);
    chk("R4 mask all", irqReq, 0);
    acc(1'b1, 8'h21, 2'd0, 8'h00);
    chk("R4 enable all", irqReq, 1);
  endtask

  task automatic test_ack;
    acc(1'b1, 8'h20, 2'd0, 8'hF4);
    chk("R10 ack", gotAck, 1);
    chk("R5 ack no err", gotErr, 0);
    chk("R5 ack drops irq", irqReq, 0);
    readPend("R5 ack clears bit4", 64'h00);
    pulse(8'h80, 8'h00);
    chk("R4 post raises irq", irqReq, 1);
    acc(1'b1, 8'h20, 2'd0, 8'h0C);
    readPend("R5 nibble 12 clears nothing", 64'h80);
  endtask

  task automatic test_reads;
    acc(1'b0, 8'h20, 2'd3, 8'h00);
    chk("R6 quad read", gotData, 64'h80);
    chk("R6 quad no err", gotErr, 0);
    acc(1'b0, 8'h20, 2'd1, 8'h00);
    chk("R9 half read err", gotErr, 1);
    chk("R9 err data", gotData, 0);
    acc(1'b0, 8'h20, 2'd2, 8'h00);
    chk("R9 word read err", gotErr, 1);
    acc(1'b0, 8'h30, 2'd0, 8'h00);
    chk("R9 bad addr err", gotErr, 1);
  endtask

  task automatic test_secondary;
    acc(1'b1, 8'hA0, 2'd0, 8'h07);
    chk("R7 sec ack no err", gotErr, 0);
    chk("R7 irq kept", irqReq, 1);
    readPend("R7 pending kept", 64'h80);
    acc(1'b0, 8'hA0, 2'd0, 8'h00);
    chk("R7 read zero", gotData, 0);
    acc(1'b1, 8'hA1, 2'd0, 8'hFF);
    chk("R8 irq kept", irqReq, 1);
    acc(1'b0, 8'hA1, 2'd0, 8'h00);
    chk("R8 readback", gotData, 64'hFF);
    readPend("R8 pending kept", 64'h80);
  endtask

  task automatic test_errors;
    acc(1'b1, 8'h20, 2'd3, 8'h07);
    chk("R9 wide write err", gotErr, 1);
    readPend("R9 pending kept", 64'h80);
    acc(1'b1, 8'h55, 2'd0, 8'hFF);
    chk("R9 bad write err", gotErr, 1);
    chk("R9 irq kept", irqReq, 1);
    @(negedge clk);
    chk("R10 single ack", busAck, 0);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_post_clear();
    test_mask();
    test_ack();
    test_reads();
    test_secondary();
    test_errors();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule